// File: doc/BRIEF.md
# Multiplex-Mode Segment Memory Loader

This block takes a stream of 8-bit display bytes and unpacks them into a bit-mapped segment memory of 40 columns by 4 rows. A 1 stored at a position means that display element is lit; a 0 means it is dark. The number of rows a byte covers in each column follows the selected multiplex drive mode. With one row the byte spreads over eight columns. With two rows it spreads over four columns. With three rows it spreads over three columns, in groups of 3, 3 and 2 bits. With four rows it spreads over two columns.

Bytes arrive on a valid/ready stream. The block accepts a byte when `in_valid` and `in_ready` are both high at a rising clock edge. It then writes one column per clock and holds `in_ready` low until the last column of that byte is stored. A sender that keeps `in_valid` high with stable data simply waits, so no byte is lost. The sender may not withdraw or change a byte while it is being offered and not yet taken.

A separate load input places the column pointer anywhere in the memory. A combinational read port lets a display scanner fetch any 4-bit column word.

Top module: `seg_ram_loader`

## Requirements
- R1: After reset every memory bit reads 0, the column pointer is 0 and `in_ready` is high.
- R2: A byte is taken at an edge where `in_valid` and `in_ready` are both high. One column is then written per clock. `in_ready` stays low for 8, 4, 3 or 2 cycles for `mode` codes 0, 1, 2 and 3 (static, 1:2, 1:3, 1:4), then returns high. The mode is sampled when the byte is taken.
- R3: Byte bits are consumed from bit 7 downward. Within a column they fill row 0 upward, and then the next column begins. Static mode fills row 0 of 8 columns, 1:2 mode fills rows 0-1 of 4 columns, and 1:4 mode fills rows 0-3 of 2 columns.
- R4: In 1:3 mode the byte fills rows 0-2 of the first two columns and rows 0-1 of the third column. Row 2 of the third column keeps its old value.
- R5: Rows above those the current mode uses keep their previous contents.
- R6: The column pointer steps by one for each column written and wraps from 39 to 0. Each new byte starts at row 0 of the column the pointer holds.
- R7: When `addr_load` is high at an edge, the pointer takes `addr_val` at that edge, or 0 if `addr_val` exceeds 39. Any columns of an in-flight byte that are not yet written are dropped. A byte taken at the same edge is stored starting at the loaded column.
- R8: `rd_word` shows the memory column selected by `rd_col` combinationally, with row r on bit r. It reads 0 when `rd_col` exceeds 39.
- R9: While `in_ready` is high, no memory bit changes, whatever `mode` and `in_data` are doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Display byte is offered |
| in_data | input | 8 | Display byte, bit 7 consumed first |
| in_ready | output | 1 | Loader can take a byte this cycle |
| mode | input | 2 | Drive mode: 0 static, 1 1:2, 2 1:3, 3 1:4 |
| addr_load | input | 1 | Load the column pointer |
| addr_val | input | 6 | Column to load |
| rd_col | input | 6 | Column to read |
| rd_word | output | 4 | Column word, row r on bit r |

## Verification
The assertions assume that `addr_val`, `rd_col` and the stream inputs are driven to known values at every clocked cycle after reset. They also assume the sender keeps an offered byte in place until it is taken. The stimulus drives all inputs one time step after each rising edge and only drops or changes a byte after seeing `in_ready` high at an edge. It mixes back-to-back streams, idle gaps with changing `mode` and `in_data`, in-range and out-of-range pointer loads, and loads that cut a byte short.

// File: rtl/seg_ldr_pkg.sv
package seg_ldr_pkg;
  localparam int unsigned NCOL_DEF   = 40;
  localparam int unsigned NROW_DEF   = 4;
  localparam int unsigned BYTE_W_DEF = 8;

  typedef enum logic [1:0] {
    MUX_STATIC = 2'd0,
    MUX_TWO    = 2'd1,
    MUX_THREE  = 2'd2,
    MUX_FOUR   = 2'd3
  } mux_mode_e;

  // rows used per column in a mode
  function automatic int unsigned rows_of(mux_mode_e m);
    case (m)
      MUX_STATIC: rows_of = 1;
      MUX_TWO:    rows_of = 2;
      MUX_THREE:  rows_of = 3;
      default:    rows_of = 4;
    endcase
  endfunction

  // columns a byte of width bw spans in a mode
  function automatic int unsigned steps_of(mux_mode_e m, int unsigned bw);
    steps_of = (bw + rows_of(m) - 1) / rows_of(m);
  endfunction

  // bits written at step index s; the last step takes the remainder
  function automatic int unsigned bits_at(mux_mode_e m, int unsigned s, int unsigned bw);
    if (s == steps_of(m, bw) - 1) bits_at = bw - rows_of(m) * s;
    else                          bits_at = rows_of(m);
  endfunction
endpackage

// File: rtl/sl_col_ptr.sv
module sl_col_ptr #(
  parameter int unsigned NCOL  = 40,
  parameter int unsigned COL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] load_val,
  input  logic             adv,
  output logic [COL_W-1:0] ptr
);
  localparam logic [COL_W-1:0] LAST = COL_W'(NCOL - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)          ptr <= '0;
    else if (load)       ptr <= (load_val <= LAST) ? load_val : '0;
    else if (adv)        ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/sl_packer.sv
module sl_packer
  import seg_ldr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NROW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [BYTE_W-1:0] acc_data,
  input  mux_mode_e         acc_mode,
  input  logic              abort,
  output logic              busy,
  output logic              wr_en,
  output logic [NROW-1:0]   wr_mask,
  output logic [NROW-1:0]   wr_bits
);
  localparam int unsigned STEP_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sr_q;
  mux_mode_e         mode_q;
  logic [STEP_W-1:0] step_q;
  int unsigned       nbits;
  logic              last;

  always_comb begin
    nbits = bits_at(mode_q, 32'(step_q), BYTE_W);
    last  = (32'(step_q) == steps_of(mode_q, BYTE_W) - 1);
    wr_en = busy & ~abort;
  end

  for (genvar r = 0; r < NROW; r++) begin : g_row
    assign wr_mask[r] = (r < nbits);
    assign wr_bits[r] = sr_q[BYTE_W-1-r];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= '0;
      mode_q <= MUX_STATIC;
      step_q <= '0;
      busy   <= 1'b0;
    end else begin
      if (abort) begin
        busy <= 1'b0;
      end else if (wr_en) begin
        sr_q   <= sr_q << nbits;
        step_q <= step_q + 1'b1;
        if (last) busy <= 1'b0;
      end
      if (acc) begin
        sr_q   <= acc_data;
        mode_q <= acc_mode;
        step_q <= '0;
        busy   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sl_col_mem.sv
module sl_col_mem #(
  parameter int unsigned NCOL  = 40,
  parameter int unsigned NROW  = 4,
  parameter int unsigned COL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [COL_W-1:0] wr_col,
  input  logic [NROW-1:0]  wr_mask,
  input  logic [NROW-1:0]  wr_bits,
  input  logic [COL_W-1:0] rd_col,
  output logic [NROW-1:0]  rd_word
);
  logic [NROW-1:0] cols [NCOL];

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    always_ff @(posedge clk) begin
      if (!rst_n) cols[c] <= '0;
      else if (wr_en && wr_col == COL_W'(c))
        cols[c] <= (cols[c] & ~wr_mask) | (wr_bits & wr_mask);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NCOL; c++)
      if (rd_col == COL_W'(c)) rd_word = cols[c];
  end
endmodule

// File: rtl/seg_ram_loader.sv
module seg_ram_loader
  import seg_ldr_pkg::*;
#(
  parameter int unsigned NCOL   = NCOL_DEF,
  parameter int unsigned NROW   = NROW_DEF,
  parameter int unsigned BYTE_W = BYTE_W_DEF,
  localparam int unsigned COL_W = $clog2(NCOL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic [1:0]        mode,
  input  logic              addr_load,
  input  logic [COL_W-1:0]  addr_val,
  input  logic [COL_W-1:0]  rd_col,
  output logic [NROW-1:0]   rd_word
);
  logic             busy;
  logic             acc;
  logic             wr_en;
  logic [NROW-1:0]  wr_mask;
  logic [NROW-1:0]  wr_bits;
  logic [COL_W-1:0] ptr;

  assign in_ready = ~busy;
  assign acc      = in_valid & in_ready;

  sl_packer #(.BYTE_W(BYTE_W), .NROW(NROW)) u_pack (
    .clk(clk), .rst_n(rst_n), .acc(acc), .acc_data(in_data),
    .acc_mode(mux_mode_e'(mode)), .abort(addr_load), .busy(busy),
    .wr_en(wr_en), .wr_mask(wr_mask), .wr_bits(wr_bits)
  );

  sl_col_ptr #(.NCOL(NCOL), .COL_W(COL_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .load_val(addr_val),
    .adv(wr_en), .ptr(ptr)
  );

  sl_col_mem #(.NCOL(NCOL), .NROW(NROW), .COL_W(COL_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_col(ptr),
    .wr_mask(wr_mask), .wr_bits(wr_bits), .rd_col(rd_col), .rd_word(rd_word)
  );
endmodule

// File: rtl/sl_loader_chk.sv
module sl_loader_chk #(
  parameter int unsigned NCOL  = 40,
  parameter int unsigned NROW  = 4,
  parameter int unsigned COL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             addr_load,
  input logic [COL_W-1:0] addr_val,
  input logic [COL_W-1:0] rd_col,
  input logic [NROW-1:0]  rd_word,
  input logic [COL_W-1:0] ptr
);
  localparam logic [COL_W-1:0] LAST = COL_W'(NCOL - 1);

  AST_STALL_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !addr_load) |=> !in_ready); // R2
  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !addr_load) |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)); // R6
  AST_LOAD_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_load && addr_val <= LAST) |=> ptr == $past(addr_val)); // R7
  AST_LOAD_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_load && addr_val > LAST) |=> ptr == '0); // R7
  AST_READ_OOR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_col > LAST) |-> rd_word == '0); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> (rd_col != $past(rd_col)) || (rd_word == $past(rd_word))); // R9
endmodule

bind seg_ram_loader sl_loader_chk #(.NCOL(NCOL), .NROW(NROW), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .addr_load(addr_load), .addr_val(addr_val), .rd_col(rd_col),
  .rd_word(rd_word), .ptr(ptr)
);

// File: tb/sim_seg_ram_loader.sv
module sim_seg_ram_loader;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       in_valid = 0;
  logic [7:0] in_data = 0;
  logic       in_ready;
  logic [1:0] mode = 0;
  logic       addr_load = 0;
  logic [5:0] addr_val = 0;
  logic [5:0] rd_col = 0;
  logic [3:0] rd_word;

  int n_chk = 0;
  int n_bad = 0;
  string cur_tag = "R1";
  bit done = 0;

  seg_ram_loader u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .mode(mode), .addr_load(addr_load),
    .addr_val(addr_val), .rd_col(rd_col), .rd_word(rd_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [3:0] mdl [40];
  int m_ptr, m_step, m_mode;
  bit m_busy;
  logic [7:0] m_sr;

  function automatic int nsteps(int m);
    case (m) 0: return 8; 1: return 4; 2: return 3; default: return 2; endcase
  endfunction
  function automatic int nbits(int m, int s);
    case (m) 0: return 1; 1: return 2; 2: return (s == 2) ? 2 : 3; default: return 4; endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mdl[i]) mdl[i] = 4'h0;
      m_ptr = 0; m_busy = 0; m_step = 0; m_mode = 0; m_sr = 0;
    end else begin
      bit take;
      take = in_valid && !m_busy;
      if (addr_load) begin
        m_ptr = (addr_val < 40) ? int'(addr_val) : 0;
        m_busy = 0;
      end else if (m_busy) begin
        int n;
        n = nbits(m_mode, m_step);
        for (int r = 0; r < n; r++) mdl[m_ptr][r] = m_sr[7-r];
        m_sr = m_sr << n;
        m_ptr = (m_ptr + 1) % 40;
        m_step++;
        if (m_step == nsteps(m_mode)) m_busy = 0;
      end
      if (take) begin
        m_sr = in_data; m_mode = int'(mode); m_step = 0; m_busy = 1;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    int exp_w;
    exp_w = (rd_col < 40) ? int'(mdl[rd_col]) : 0;
    check("R2 in_ready", int'(in_ready), rst_n ? int'(!m_busy) : 1);
    check({cur_tag, " rd_word"}, int'(rd_word), rst_n ? exp_w : 0);
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send(logic [7:0] d, logic [1:0] m);
    in_valid = 1; in_data = d; mode = m;
    do @(posedge clk); while (!in_ready);
    #1 in_valid = 0;
  endtask

  task automatic drain();
    while (!in_ready) tick();
    tick();
  endtask

  task automatic load(logic [5:0] a);
    addr_load = 1; addr_val = a; tick(); addr_load = 0;
  endtask

  task automatic sweep(string tag);
    cur_tag = tag;
    for (int c = 0; c < 46; c++) begin rd_col = 6'(c); tick(); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    sweep("R1");          // reset state over several columns
    rst_n = 1; tick();
    // R3: static, 1:2 and 1:4 bit order
    send(8'hA5, 2'd0); drain(); sweep("R3 static");
    load(6'd10); send(8'hC6, 2'd1); drain(); sweep("R3 mux2");
    load(6'd20); send(8'h9E, 2'd3); drain(); sweep("R3 mux4");
    // R5: all ones in 1:4, then zeros in static over them
    load(6'd24); send(8'hFF, 2'd3); send(8'hFF, 2'd3); drain();
    load(6'd24); send(8'h00, 2'd0); drain(); sweep("R5");
    // R4: 1:3 over all ones keeps row 2 of third column
    load(6'd30); send(8'hFF, 2'd3); send(8'hFF, 2'd3); drain();
    load(6'd30); send(8'h00, 2'd2); drain(); sweep("R4");
    // R6: wrap from 39
    load(6'd38); send(8'h5A, 2'd1); send(8'h3C, 2'd2); drain(); sweep("R6");
    // R7: out-of-range load, mid-byte abort, load with simultaneous take
    load(6'd50); send(8'h81, 2'd0); drain(); sweep("R7 oor");
    load(6'd5); in_valid = 1; in_data = 8'hFF; mode = 2'd0; tick();
    in_valid = 0; tick(2); load(6'd15); drain();
    addr_load = 1; addr_val = 6'd33; in_valid = 1; in_data = 8'h77; mode = 2'd3;
    tick(); addr_load = 0; in_valid = 0; drain(); sweep("R7 abort");
    // R9: idle with moving mode and data
    cur_tag = "R9";
    for (int i = 0; i < 30; i++) begin
      mode = 2'($urandom); in_data = 8'($urandom); rd_col = 6'($urandom_range(0, 39)); tick();
    end
    sweep("R9");
    // R2: streams with mode change while busy, random loads
    cur_tag = "R2";
    for (int i = 0; i < 400; i++) begin
      rd_col = 6'($urandom_range(0, 45));
      if ($urandom_range(0, 15) == 0) load(6'($urandom_range(0, 47)));
      else if ($urandom_range(0, 3) != 0) begin
        send(8'($urandom), 2'($urandom));
        mode = 2'($urandom);
      end else tick();
    end
    drain(); sweep("R8");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule